// File: doc/BRIEF.md
# Serial Byte Transmitter with Completion and Break Control

This block serializes words onto an asynchronous transmit line. Software or a feeder places one word at a time into a single holding register. The holding register passes its contents to a frame shifter as soon as the shifter is free, so the next word can be written while the current frame is still going out. The line idles high. Every bit lasts one period of an external baud tick, and the shifter moves on by one bit on each tick.

When the transmit enable rises, the shifter first sends one frame of all-high bits, and only then sends queued traffic. A single-cycle break request queues a frame that holds the line low. The pending-break flag drops by itself once that frame has been sent. A sticky completion flag reports that the line has gone quiet with nothing left queued, and only an explicit clear strobe resets it. Word length (8 or 9 bits) and stop-bit count (1 or 2) are read each time a frame is loaded.

Top module: `uart_tx_core`

## Requirements
- R1: After a synchronous reset the line is high, the buffer-empty flag is 1, the completion flag is 1 and the break-pending flag is 0.
- R2: A rising transmit enable makes the block send one all-high frame of 1+N+S bit times before any other frame, where N is the word length and S the stop count. No frame is loaded while the enable is low.
- R3: A data frame is one low start bit, then N data bits LSB first, then S high stop bits, one bit per baud tick. N=8 when cfg_nine=0 (wr_data[8] is then ignored) and N=9 when cfg_nine=1. S=1 when cfg_two_stop=0 and S=2 when cfg_two_stop=1. The line changes only after a clock edge on which baud_tick was high.
- R4: An accepted write clears buffer-empty. Buffer-empty sets again on the tick edge where the word enters the shifter, which is the same edge that drives the start bit.
- R5: A write while buffer-empty is 0 is ignored and does not replace the held word.
- R6: When a word is waiting, its start bit directly follows the last stop bit of the previous frame, so consecutive frame starts are exactly 1+N+S ticks apart.
- R7: The completion flag sets on the tick edge that ends a frame if no new frame is loaded on that edge. It then stays set, and writes to the data register do not clear it.
- R8: A tc_clr strobe clears the completion flag. If a clear and a set fall in the same cycle, the set wins.
- R9: A brk_req strobe sets break-pending. The break frame is N+2 low bit times followed by one high bit. Break-pending clears on the edge that ends that frame. A pending break goes out before a waiting data word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle strobe per bit time |
| tx_en | input | 1 | Transmit enable |
| cfg_nine | input | 1 | 1 selects 9-bit words, 0 selects 8-bit words |
| cfg_two_stop | input | 1 | 1 selects two stop bits, 0 selects one |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_MAX | Word to transmit |
| brk_req | input | 1 | Break request strobe |
| tc_clr | input | 1 | Write-one-to-clear strobe for the completion flag |
| tx_line | output | 1 | Serial output, idle high |
| buf_empty | output | 1 | Holding register can accept a word |
| tx_done | output | 1 | Sticky completion flag |
| brk_pend | output | 1 | Break request not yet sent |

## Verification
Two events can land in the same clock: the completion flag setting at the end of a frame, and a clear strobe from outside. The bench counts baud ticks from the load of a single frame and raises tc_clr exactly in the cycle whose rising edge carries the final tick. It then expects the flag to read 1 on the next sample. A second collision is a break request written in the same cycle as a data word. The recovered stream must show the break first and the data frame N+3 ticks later. All frames are recovered from the line by a tick-sampling decoder in the bench, and their values and start times are compared with arithmetic expectations.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [1:0] {
    KIND_FILL  = 2'd0,
    KIND_WORD  = 2'd1,
    KIND_BREAK = 2'd2
  } frame_kind_e;
endpackage

// File: rtl/uart_tx_holdreg.sv
module uart_tx_holdreg #(
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          take,
  output logic [DW-1:0] held,
  output logic          empty
);
  always_ff @(posedge clk) begin
    if (rst) begin
      held  <= '0;
      empty <= 1'b1;
    end else if (take) begin
      empty <= 1'b1;
    end else if (wr_en && empty) begin
      held  <= wr_data;
      empty <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_tx_framegen.sv
module uart_tx_framegen
  import uart_tx_pkg::*;
#(
  parameter int DW = 9,
  parameter int FW = DW + 3,
  parameter int CW = $clog2(FW + 1)
) (
  input  frame_kind_e   kind,
  input  logic          cfg_nine,
  input  logic          cfg_two_stop,
  input  logic [DW-1:0] word,
  output logic [FW-1:0] frame,
  output logic [CW-1:0] len
);
  logic [FW-1:0] word_ext;
  int            nbits;
  int            nstop;

  assign word_ext = FW'({word, 1'b0});
  assign nbits    = cfg_nine ? DW : DW - 1;
  assign nstop    = cfg_two_stop ? 2 : 1;

  always_comb begin
    frame = '1;
    for (int i = 0; i < FW; i++) begin
      case (kind)
        KIND_WORD:  frame[i] = (i <= nbits) ? word_ext[i] : 1'b1;
        KIND_BREAK: frame[i] = (i <= nbits + 1) ? 1'b0 : 1'b1;
        default:    frame[i] = 1'b1;
      endcase
    end
  end

  always_comb begin
    if (kind == KIND_BREAK) len = CW'(nbits + 3);
    else                    len = CW'(1 + nbits + nstop);
  end
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter #(
  parameter int FW = 12,
  parameter int CW = $clog2(FW + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          load,
  input  logic [FW-1:0] frame_in,
  input  logic [CW-1:0] len_in,
  output logic          line,
  output logic          busy,
  output logic          ending
);
  logic [FW-1:0] sh;
  logic [CW-1:0] left;

  assign ending = tick && busy && (left == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '1;
      left <= '0;
      busy <= 1'b0;
      line <= 1'b1;
    end else if (tick) begin
      if (load) begin
        sh   <= frame_in;
        left <= len_in;
        busy <= 1'b1;
        line <= frame_in[0];
      end else if (busy) begin
        if (left == CW'(1)) begin
          busy <= 1'b0;
          line <= 1'b1;
        end else begin
          sh   <= {1'b1, sh[FW-1:1]};
          left <= left - CW'(1);
          line <= sh[1];
        end
      end
    end
  end
endmodule

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uart_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        tick,
  input  logic        tx_en,
  input  logic        brk_req,
  input  logic        tc_clr,
  input  logic        buf_empty,
  input  logic        busy,
  input  logic        ending,
  output logic        load,
  output frame_kind_e kind,
  output logic        take,
  output logic        tx_done,
  output logic        brk_pend
);
  logic        en_q;
  logic        fill_owed;
  frame_kind_e cur_kind;
  logic        brk_avail;
  logic        slot_free;

  assign brk_avail = brk_pend && !(ending && cur_kind == KIND_BREAK);
  assign slot_free = tick && en_q && (!busy || ending);

  always_comb begin
    if (fill_owed)      kind = KIND_FILL;
    else if (brk_avail) kind = KIND_BREAK;
    else                kind = KIND_WORD;
  end

  assign load = slot_free && (fill_owed || brk_avail || !buf_empty);
  assign take = load && (kind == KIND_WORD);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= 1'b0;
      fill_owed <= 1'b0;
      cur_kind  <= KIND_FILL;
      brk_pend  <= 1'b0;
      tx_done   <= 1'b1;
    end else begin
      en_q <= tx_en;
      if (tx_en && !en_q)                  fill_owed <= 1'b1;
      else if (load && kind == KIND_FILL)  fill_owed <= 1'b0;
      if (load) cur_kind <= kind;
      if (ending && cur_kind == KIND_BREAK) brk_pend <= 1'b0;
      else if (brk_req)                     brk_pend <= 1'b1;
      if (ending && !load) tx_done <= 1'b1;
      else if (tc_clr)     tx_done <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
  import uart_tx_pkg::*;
#(
  parameter int DATA_MAX = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                baud_tick,
  input  logic                tx_en,
  input  logic                cfg_nine,
  input  logic                cfg_two_stop,
  input  logic                wr_en,
  input  logic [DATA_MAX-1:0] wr_data,
  input  logic                brk_req,
  input  logic                tc_clr,
  output logic                tx_line,
  output logic                buf_empty,
  output logic                tx_done,
  output logic                brk_pend
);
  localparam int FW = DATA_MAX + 3;
  localparam int CW = $clog2(FW + 1);

  logic [DATA_MAX-1:0] held;
  logic                take;
  logic                load;
  logic                busy;
  logic                ending;
  frame_kind_e         kind;
  logic [FW-1:0]       frame;
  logic [CW-1:0]       len;

  uart_tx_holdreg #(.DW(DATA_MAX)) u_hold (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .take(take), .held(held), .empty(buf_empty)
  );

  uart_tx_framegen #(.DW(DATA_MAX), .FW(FW), .CW(CW)) u_gen (
    .kind(kind), .cfg_nine(cfg_nine), .cfg_two_stop(cfg_two_stop),
    .word(held), .frame(frame), .len(len)
  );

  uart_tx_shifter #(.FW(FW), .CW(CW)) u_shift (
    .clk(clk), .rst(rst), .tick(baud_tick), .load(load),
    .frame_in(frame), .len_in(len), .line(tx_line),
    .busy(busy), .ending(ending)
  );

  uart_tx_ctrl u_ctrl (
    .clk(clk), .rst(rst), .tick(baud_tick), .tx_en(tx_en),
    .brk_req(brk_req), .tc_clr(tc_clr), .buf_empty(buf_empty),
    .busy(busy), .ending(ending), .load(load), .kind(kind),
    .take(take), .tx_done(tx_done), .brk_pend(brk_pend)
  );
endmodule

// File: rtl/uart_tx_core_chk.sv
module uart_tx_core_chk (
  input logic clk,
  input logic rst,
  input logic baud_tick,
  input logic wr_en,
  input logic brk_req,
  input logic tc_clr,
  input logic tx_line,
  input logic buf_empty,
  input logic tx_done,
  input logic brk_pend
);
  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (rst)
    wr_en && buf_empty |=> !buf_empty);                       // R4
  AST_EMPTY_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    !buf_empty && !baud_tick |=> !buf_empty);                  // R4
  AST_LINE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    !baud_tick |=> $stable(tx_line));                          // R3
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    tx_done && !tc_clr |=> tx_done);                           // R7
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (rst)
    tc_clr && !baud_tick |=> !tx_done);                        // R8
  AST_BRK_RAISE: assert property (@(posedge clk) disable iff (rst)
    brk_req && !brk_pend |=> brk_pend);                        // R9
  AST_BRK_HOLD: assert property (@(posedge clk) disable iff (rst)
    brk_pend && !baud_tick |=> brk_pend);                      // R9
endmodule

bind uart_tx_core uart_tx_core_chk u_chk (.*);

// File: tb/uart_tx_core_test.sv
`timescale 1ns/1ps
module uart_tx_core_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tx_en = 1'b0, cfg_nine = 1'b0, cfg_two_stop = 1'b0;
  logic       wr_en = 1'b0, brk_req = 1'b0, tc_clr = 1'b0;
  logic [8:0] wr_data = '0;
  logic       tx_line, buf_empty, tx_done, brk_pend;
  logic       baud_tick;
  logic [1:0] phase = '0;
  logic       last_tick = 1'b0;
  int         tick_edges = 0;
  int         vectors = 0, fails = 0, frame_err = 0;
  bit         done = 1'b0;
  int         cur_n = 8, cur_s = 1;

  int rx_val [0:511];
  int rx_edge[0:511];
  int rx_cnt = 0;
  int dst = 0, dbit = 0, acc = 0, sti = 0, st_edge = 0;

  always #2 clk = ~clk;

  uart_tx_core uut (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .tx_en(tx_en),
    .cfg_nine(cfg_nine), .cfg_two_stop(cfg_two_stop), .wr_en(wr_en),
    .wr_data(wr_data), .brk_req(brk_req), .tc_clr(tc_clr),
    .tx_line(tx_line), .buf_empty(buf_empty), .tx_done(tx_done),
    .brk_pend(brk_pend)
  );

  assign baud_tick = (phase == 2'd3);
  always @(posedge clk) begin
    phase     <= phase + 2'd1;
    last_tick <= baud_tick;
    if (baud_tick) tick_edges <= tick_edges + 1;
  end

  // line decoder: one sample per tick edge
  always @(negedge clk) begin
    if (!rst && last_tick) begin
      case (dst)
        0: if (!tx_line) begin dst = 1; dbit = 0; acc = 0; st_edge = tick_edges; end
        1: begin
          if (tx_line) acc = acc | (1 << dbit);
          dbit++;
          if (dbit == cur_n) begin dst = 2; sti = 0; end
        end
        2: if (tx_line) begin
          sti++;
          if (sti == cur_s) begin
            rx_val[rx_cnt] = acc; rx_edge[rx_cnt] = st_edge; rx_cnt++; dst = 0;
          end
        end else if (sti == 0 && acc == 0) dst = 3;
        else begin frame_err++; dst = 0; end
        default: begin
          if (tx_line) begin rx_val[rx_cnt] = -1; rx_edge[rx_cnt] = st_edge; rx_cnt++; end
          else frame_err++;
          dst = 0;
        end
      endcase
    end
  end

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_edge(int n);
    while (tick_edges < n) @(negedge clk);
  endtask

  task automatic send(logic [8:0] v);
    int t = 0;
    while (!buf_empty && t < 4000) begin @(negedge clk); t++; end
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!tx_done && t < 8000) begin @(negedge clk); t++; end
  endtask

  task automatic clear_tc();
    tc_clr = 1'b1; @(negedge clk); tc_clr = 1'b0;
  endtask

  task automatic enable_aligned(output int en_edge);
    wait_edge(tick_edges + 1);
    tx_en = 1'b1;
    en_edge = tick_edges;
  endtask

  initial begin
    #800000;
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int en_edge, base, L, nv, s, b;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 line", tx_line, 1);
    check("R1 buf_empty", buf_empty, 1);
    check("R1 tx_done", tx_done, 1);
    check("R1 brk_pend", brk_pend, 0);

    // sweep all four formats
    for (int c = 0; c < 4; c++) begin
      cfg_nine = c[1]; cfg_two_stop = c[0];
      cur_n = c[1] ? 9 : 8; cur_s = c[0] ? 2 : 1;
      L = 1 + cur_n + cur_s;
      clear_tc();
      check("R8 clear", tx_done, 0);
      enable_aligned(en_edge);
      base = rx_cnt;
      nv = (c == 0) ? 256 : 24;
      for (int k = 0; k < nv; k++) begin
        if (c == 0) send(9'(k | ((k & 1) << 8)));
        else send(9'((k * 151 + 77 + c) & ((1 << cur_n) - 1)));
      end
      wait_done();
      s = rx_edge[rx_cnt - 1];
      check("R7 done edge", tick_edges, s + L);
      check("R3 frame count", rx_cnt - base, nv);
      check("R2 fill frame", rx_edge[base], en_edge + L + 1);
      for (int k = 0; k < nv; k++) begin
        if (c == 0) check("R3 value", rx_val[base + k], k & 255);
        else check("R3 value", rx_val[base + k], (k * 151 + 77 + c) & ((1 << cur_n) - 1));
        if (k > 0) check("R6 spacing", rx_edge[base + k] - rx_edge[base + k - 1], L);
      end
      @(negedge clk);
      tx_en = 1'b0;
      repeat (8) @(negedge clk);
    end

    // R5 ignored write, R2 nothing while disabled
    cfg_nine = 1'b0; cfg_two_stop = 1'b0; cur_n = 8; cur_s = 1; L = 10;
    clear_tc();
    send(9'h05A);
    check("R4 cleared by write", buf_empty, 0);
    wr_en = 1'b1; wr_data = 9'h0C3; @(negedge clk); wr_en = 1'b0;
    check("R5 still full", buf_empty, 0);
    base = rx_cnt;
    wait_edge(tick_edges + 30);
    check("R2 no load when off", rx_cnt - base, 0);
    enable_aligned(en_edge);
    wait_done();
    check("R5 one frame", rx_cnt - base, 1);
    check("R5 held word", rx_val[base], 32'h5A);
    check("R2 fill first", rx_edge[base], en_edge + L + 1);

    // R4 transfer edge, R7 not cleared by write, R8 collision
    send(9'h081);
    while (!buf_empty) @(negedge clk);
    check("R4 start on transfer", tx_line, 0);
    check("R4 on tick edge", last_tick, 1);
    check("R7 write keeps done", tx_done, 1);
    s = tick_edges;
    clear_tc();
    check("R8 mid-frame clear", tx_done, 0);
    while (!(tick_edges == s + L - 1 && baud_tick)) @(negedge clk);
    tc_clr = 1'b1;
    @(negedge clk);
    tc_clr = 1'b0;
    check("R8 set wins", tx_done, 1);
    check("R8 collision edge", tick_edges, s + L);

    // R9 break with a word written in the same cycle, two formats
    for (int c = 0; c < 2; c++) begin
      cfg_nine = c[0]; cfg_two_stop = c[0];
      cur_n = c[0] ? 9 : 8; cur_s = c[0] ? 2 : 1;
      repeat (8) @(negedge clk);
      clear_tc();
      b = rx_cnt;
      wr_en = 1'b1; wr_data = 9'h03C; brk_req = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; brk_req = 1'b0;
      check("R9 pending", brk_pend, 1);
      wait_done();
      check("R9 break first", rx_val[b], -1);
      check("R9 word after", rx_val[b + 1], 32'h3C);
      check("R9 break length", rx_edge[b + 1] - rx_edge[b], cur_n + 3);
      check("R9 pending cleared", brk_pend, 0);
    end
    check("R3 framing errors", frame_err, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule